// File: doc/BRIEF.md
# External Interrupt Sequencer

The sequencer sits beside the pipeline of a simple 32-bit processor. It collects 32 level interrupt request lines into a sticky pending register. It also holds a software mask register, a two-bit enable register and an exception base register. At every instruction boundary that the core signals, it decides whether to take an interrupt. When it takes one, it emits a single-cycle `take` pulse together with three values: the return PC to save, the index of the general register that receives it (30), and the redirect vector. The vector is the exception base plus the interrupt exception ID times 32. At the same time it moves the global enable into the saved-enable bit and clears the global enable.

Software reaches the registers through a simple select/write/read port. Pending bits are cleared by writing ones to them. Mask, enable and base are written directly. Reads are combinational.

The control path is a three-state machine:
- `ST_QUIET`: nothing serviceable.
- `ST_ARMED`: an enabled, unmasked interrupt is pending, but no boundary has been seen yet.
- `ST_VECTOR`: the cycle in which `take` is high.

Its transitions are:
- QUIET/ARMED → VECTOR on boundary while serviceable (the "fire" transition).
- QUIET ↔ ARMED as serviceability changes, with no boundary.
- VECTOR → QUIET or ARMED, chosen by the current serviceability.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the pending, mask and enable registers read zero, the base register reads zero, and `take` is low.
- R2: A request line that is high at a clock edge sets its pending bit (line i → bit i). The bit stays set after the line drops.
- R3: Writing select 0 (pending) clears every pending bit written as 1. A line that is high at the same edge keeps its bit set.
- R4: Select 1 (mask) stores all 32 bits. Select 2 (enable) stores bits 1:0, where bit 0 is the global enable and bit 1 is the saved enable. Select 3 (base) stores bits 31:8, and bits 7:0 read zero.
- R5: An interrupt is taken only if enable bit 0 is 1 and (mask AND pending) is nonzero at a clock edge where `boundary` is high. `take` is then high for exactly the following cycle.
- R6: With `take`, `ret_pc` equals the `cur_pc` presented at the boundary edge, and `ret_reg` equals 30.
- R7: With `take`, `vector` equals base + 6×32.
- R8: After a take, the enable register reads 2. A software enable write at the same edge as the take is overridden.
- R9: No take occurs while `boundary` is low, even when serviceable. A pending interrupt that is unmasked or enabled later is taken at the next boundary, with no new request edge.
- R10: Two consecutive cycles never both have `take` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level interrupt requests |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Selected register value |
| boundary | input | 1 | Core is at an instruction boundary |
| cur_pc | input | 32 | PC of the next instruction at the boundary |
| take | output | 1 | Interrupt taken (one cycle) |
| ret_pc | output | 32 | PC to save |
| ret_reg | output | 5 | General register index for the saved PC |
| vector | output | 32 | Redirect fetch address |

## Verification
Two pairs of functions can land in the same clock edge. In the first, a request line is held high during the edge that also carries a write-one-to-clear of all pending bits. The bench then reads back that only the held bit survives. In the second, the core asserts `boundary` while software writes the enable register. The take must win, so the enable register reads 2 afterwards, and `take` must still carry the right PC and vector. The bench sweeps all 32 lines through the set, clear and take paths and computes each expected vector from the base it programmed.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    // Register select encoding on the software port
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_ENAB = 2'd2,
        SEL_BASE = 2'd3
    } csr_sel_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_VECTOR = 2'd2
    } seq_state_e;

endpackage

// File: rtl/irqs_pending.sv
module irqs_pending #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pend
);

    // One sticky bit per line; a high line overrides a same-edge clear
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (lines[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqs_csr.sv
module irqs_csr
    import irqs_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NUM_LINES = 32,
    parameter int BASE_LSB  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           sel,
    input  logic [XLEN-1:0]      wdata,
    input  logic                 take_fire,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] mask,
    output logic [1:0]           ie,
    output logic [XLEN-1:0]      base,
    output logic [XLEN-1:0]      rdata
);

    localparam int BASE_W = XLEN - BASE_LSB;

    logic [BASE_W-1:0] base_hi;
    csr_sel_e          sel_e;

    assign sel_e = csr_sel_e'(sel);
    assign base  = {base_hi, {BASE_LSB{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            ie      <= 2'b00;
            base_hi <= '0;
        end else begin
            if (wr_en && sel_e == SEL_MASK) mask    <= wdata[NUM_LINES-1:0];
            if (wr_en && sel_e == SEL_BASE) base_hi <= wdata[XLEN-1:BASE_LSB];
            // Taking an interrupt has priority over a software enable write
            if (take_fire) begin
                ie <= {ie[0], 1'b0};
            end else if (wr_en && sel_e == SEL_ENAB) begin
                ie <= wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel_e)
            SEL_PEND: rdata = XLEN'(pend);
            SEL_MASK: rdata = XLEN'(mask);
            SEL_ENAB: rdata = XLEN'(ie);
            SEL_BASE: rdata = base;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqs_fsm.sv
module irqs_fsm
    import irqs_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int EXC_ID    = 6,
    parameter int VEC_SHIFT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  logic            serviceable,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] base,
    output logic            take_fire,
    output logic            take,
    output logic [XLEN-1:0] ret_pc,
    output logic [XLEN-1:0] vector
);

    localparam logic [XLEN-1:0] VEC_OFF = XLEN'(EXC_ID) << VEC_SHIFT;

    seq_state_e state, nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= nxt;
    end

    // Next state and fire decision
    always_comb begin
        nxt       = state;
        take_fire = 1'b0;
        unique case (state)
            ST_QUIET, ST_ARMED: begin
                if (boundary && serviceable) begin
                    nxt       = ST_VECTOR;
                    take_fire = 1'b1;
                end else begin
                    nxt = serviceable ? ST_ARMED : ST_QUIET;
                end
            end
            ST_VECTOR: nxt = serviceable ? ST_ARMED : ST_QUIET;
            default:   nxt = ST_QUIET;
        endcase
    end

    // Outputs: captured payload and pulse from state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc <= '0;
            vector <= '0;
        end else if (take_fire) begin
            ret_pc <= cur_pc;
            vector <= base + VEC_OFF;
        end
    end

    assign take = (state == ST_VECTOR);

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irqs_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NUM_LINES = 32,
    parameter int EXC_ID    = 6,
    parameter int VEC_SHIFT = 5,
    parameter int BASE_LSB  = 8,
    parameter int RET_REG   = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     irq_lines,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [31:0]     csr_wdata,
    output logic [31:0]     csr_rdata,
    input  logic            boundary,
    input  logic [31:0]     cur_pc,
    output logic            take,
    output logic [31:0]     ret_pc,
    output logic [4:0]      ret_reg,
    output logic [31:0]     vector
);

    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] clr_eff;
    logic [1:0]           ie_q;
    logic [XLEN-1:0]      base_q;
    logic                 serviceable;
    logic                 take_fire;

    assign clr_eff = (csr_we && csr_sel_e'(csr_sel) == SEL_PEND)
                     ? csr_wdata[NUM_LINES-1:0] : '0;
    assign serviceable = ie_q[0] && (|(mask_q & pend_q));
    assign ret_reg     = 5'(RET_REG);

    irqs_pending #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines[NUM_LINES-1:0]),
        .clr_mask (clr_eff),
        .pend     (pend_q)
    );

    irqs_csr #(.XLEN(XLEN), .NUM_LINES(NUM_LINES), .BASE_LSB(BASE_LSB)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_we),
        .sel       (csr_sel),
        .wdata     (csr_wdata),
        .take_fire (take_fire),
        .pend      (pend_q),
        .mask      (mask_q),
        .ie        (ie_q),
        .base      (base_q),
        .rdata     (csr_rdata)
    );

    irqs_fsm #(.XLEN(XLEN), .EXC_ID(EXC_ID), .VEC_SHIFT(VEC_SHIFT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .serviceable (serviceable),
        .cur_pc      (cur_pc),
        .base        (base_q),
        .take_fire   (take_fire),
        .take        (take),
        .ret_pc      (ret_pc),
        .vector      (vector)
    );

endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] lines,
    input logic [NUM_LINES-1:0] clr_eff,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] mask,
    input logic [1:0]           ie,
    input logic                 boundary,
    input logic [31:0]          cur_pc,
    input logic                 take,
    input logic [31:0]          ret_pc
);

    // R2
    line_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & $past(lines)) == $past(lines));

    // R3
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr_eff)) & ~pend) == '0);

    // R5
    take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary) && $past(ie[0]) && ($past(mask & pend) != '0));

    // R6
    take_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ret_pc == $past(cur_pc));

    // R8
    take_moves_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ie == 2'b10);

    // R10
    take_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

endmodule

bind irq_sequencer irqs_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines[NUM_LINES-1:0]),
    .clr_eff  (clr_eff),
    .pend     (pend_q),
    .mask     (mask_q),
    .ie       (ie_q),
    .boundary (boundary),
    .cur_pc   (cur_pc),
    .take     (take),
    .ret_pc   (ret_pc)
);

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        boundary = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        take;
    logic [31:0] ret_pc;
    logic [4:0]  ret_reg;
    logic [31:0] vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .boundary(boundary), .cur_pc(cur_pc),
        .take(take), .ret_pc(ret_pc), .ret_reg(ret_reg), .vector(vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        csr_sel = s;
        #1;
        v = csr_rdata;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        csr_we = 1'b1; csr_sel = s; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic pulse_line(input logic [31:0] l);
        irq_lines = l;
        @(negedge clk);
        irq_lines = '0;
    endtask

    task automatic at_boundary(input logic [31:0] pc);
        cur_pc = pc; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    localparam logic [31:0] BASE = 32'h1234_5600;

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 take", {31'b0, take}, 32'h0);

        // R2/R3 sweep over every line
        for (int i = 0; i < 32; i++) begin
            pulse_line(32'h1 << i);
            @(negedge clk);
            rd(2'd0, v);
            check("R2 sticky set", v, 32'h1 << i);
            wr(2'd0, 32'h1 << i);
            rd(2'd0, v);
            check("R3 w1c", v, 32'h0);
        end

        // R3 set wins over same-edge clear
        pulse_line(32'h0000_0F01);
        irq_lines = 32'h20;
        wr(2'd0, 32'hFFFF_FFFF);
        irq_lines = '0;
        rd(2'd0, v);
        check("R3 set wins", v, 32'h20);
        wr(2'd0, 32'h20);

        // R4 register storage
        wr(2'd1, 32'hA5A5_0F0F);
        rd(2'd1, v);
        check("R4 mask", v, 32'hA5A5_0F0F);
        wr(2'd2, 32'hFFFF_FFFE);
        rd(2'd2, v);
        check("R4 enable", v, 32'h2);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v);
        check("R4 base", v, 32'hFFFF_FF00);
        wr(2'd3, BASE);

        // R5/R6/R7/R8/R10 take sweep over every line
        for (int k = 0; k < 32; k++) begin
            wr(2'd1, 32'h1 << k);
            pulse_line(32'h1 << k);
            wr(2'd2, 32'h1);
            at_boundary(32'h1000 + 32'(k) * 4);
            check("R5 take", {31'b0, take}, 32'h1);
            check("R6 ret_pc", ret_pc, 32'h1000 + 32'(k) * 4);
            check("R6 ret_reg", {27'b0, ret_reg}, 32'd30);
            check("R7 vector", vector, BASE + 32'd6 * 32'd32);
            rd(2'd2, v);
            check("R8 enable after take", v, 32'h2);
            @(negedge clk);
            check("R10 single pulse", {31'b0, take}, 32'h0);
            wr(2'd0, 32'hFFFF_FFFF);
        end

        // R5 masked and disabled cases
        pulse_line(32'h8);
        wr(2'd1, ~32'h8);
        wr(2'd2, 32'h1);
        at_boundary(32'h2000);
        check("R5 masked no take", {31'b0, take}, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h8);
        at_boundary(32'h2004);
        check("R5 disabled no take", {31'b0, take}, 32'h0);

        // R9 no boundary, then a later enable is taken
        wr(2'd2, 32'h1);
        repeat (5) begin
            @(negedge clk);
            check("R9 no boundary", {31'b0, take}, 32'h0);
        end
        at_boundary(32'h3000);
        check("R9 late take", {31'b0, take}, 32'h1);
        check("R9 late pc", ret_pc, 32'h3000);
        @(negedge clk);

        // R8 enable write collides with take
        wr(2'd2, 32'h1);
        cur_pc = 32'h4000; boundary = 1'b1;
        wr(2'd2, 32'h1);
        boundary = 1'b0;
        check("R8 collide take", {31'b0, take}, 32'h1);
        check("R8 collide pc", ret_pc, 32'h4000);
        rd(2'd2, v);
        check("R8 collide enable", v, 32'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule